// File: doc/BRIEF.md
# Double-Binary Circular Recursive Systematic Encoder

This block encodes a block of N two-bit data couples with an 8-state recursive systematic convolutional code, one couple per clock. It needs no tail bits: the trellis is closed into a circle, so the encoder ends each block in the same state it started from. To find that starting state, the block is first run once through the trellis from the all-zero state, and the couples are stored as they arrive. A small combinational map, indexed by N mod 7 and the state reached, then gives the circulation state. A second pass replays the stored couples from that state and emits the systematic pair together with two parity bits.

A host pulses `start` with the block length and the second-parity enable. It then streams the couples in with a valid/ready handshake and collects N output words, the last one marked. The encoder also reports the circulation state it used. It raises a flag beside the last word if the trellis did not close, which is a built-in self-check.

Top module: `dbcrsc_enc`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid`, `out_last`, `out_mismatch` and `len_err` are all 0.
- R2: The trellis state is {S1,S2,S3}, with S1 as bit 2 of `circ_state` and S3 as bit 0. For a couple (A,B), f = A^B^S1^S3, and the next state is S1'=f, S2'=S1^B, S3'=S2^B. The parity outputs are Y1 = f^S2^S3 and Y2 = f^S3.
- R3: After an accepted `start`, `in_ready` is 1 until exactly N couples have been taken on cycles with `in_valid` and `in_ready` both high. The first pass starts from state 0 and produces no output words.
- R4: The second pass starts from the unique state C for which encoding the block from C ends in C. C is shown on `circ_state` while the output words are issued.
- R5: The second pass issues exactly N words with `out_valid`. Each word carries the input couple on `out_a`/`out_b` in arrival order, plus the Y1/Y2 of R2. `out_last` is 1 on the Nth word only.
- R6: `y2_en` is sampled at `start`. When it was 0, `out_y2` is 0 on every word of that block.
- R7: A `start` with N=0, N>MAX_N or N a multiple of 7 is rejected. `len_err` pulses for one cycle after it and `busy` stays 0.
- R8: A `start` while `busy` is 1 is ignored. The block in progress keeps its length and output.
- R9: `out_mismatch` is 1 alongside `out_last` only if the final state of the second pass differs from C. With a correct trellis it is 0.
- R10: `in_valid` has no effect while `in_ready` is 0, whether the encoder is idle or in the second pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (one-cycle pulse) |
| blk_len | input | LEN_W | Block length N in couples, sampled with start |
| y2_en | input | 1 | Enable second parity, sampled with start |
| in_valid | input | 1 | Input couple valid |
| in_ready | output | 1 | Encoder accepts a couple this cycle |
| in_a | input | 1 | Couple bit A |
| in_b | input | 1 | Couple bit B |
| busy | output | 1 | Block in progress |
| len_err | output | 1 | One-cycle pulse on a rejected length |
| out_valid | output | 1 | Output word valid |
| out_a | output | 1 | Systematic bit A |
| out_b | output | 1 | Systematic bit B |
| out_y1 | output | 1 | First parity |
| out_y2 | output | 1 | Second parity (0 when disabled) |
| out_last | output | 1 | Last word of the block |
| out_mismatch | output | 1 | Trellis failed to close (with out_last) |
| circ_state | output | 3 | Circulation state of the current block |

## Verification
The hardest condition to reach from the ports is a block that does not close. No legal length produces one, so `out_mismatch` can only be seen to stay low. The bench works out the circulation state by brute force: it tries all eight start states for each block and checks the design's choice against it. Block lengths are chosen to cover every nonzero residue mod 7, so every column of the lookup is used. Handshake gaps, a stray `start` in mid-block and `in_valid` held high through the second pass push the control path through its less common transitions.

// File: rtl/dbcrsc_pkg.sv
package dbcrsc_pkg;

    parameter int MAX_N = 864;
    parameter int LEN_W = $clog2(MAX_N + 1);
    parameter int AW    = $clog2(MAX_N);
    parameter int PERIOD = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_CIRC,
        PH_EMIT
    } phase_t;

    typedef struct packed {
        logic a;
        logic b;
    } couple_t;

    typedef struct packed {
        logic [2:0] nxt;
        logic       y1;
        logic       y2;
    } step_t;

    // one trellis step; st[2]=S1, st[1]=S2, st[0]=S3
    function automatic step_t trellis(input logic [2:0] st, input couple_t c);
        step_t r;
        logic  fb;
        fb    = c.a ^ c.b ^ st[2] ^ st[0];
        r.nxt = {fb, st[2] ^ c.b, st[1] ^ c.b};
        r.y1  = fb ^ st[1] ^ st[0];
        r.y2  = fb ^ st[0];
        return r;
    endfunction

    // circulation state: the c with (G^n c) xor s0n == c, n = N mod 7
    function automatic logic [2:0] circ_of(input logic [2:0] nm, input logic [2:0] s0n);
        logic [2:0] res;
        logic [2:0] t;
        couple_t    z;
        z   = '0;
        res = '0;
        for (int c = 0; c < 8; c++) begin
            t = 3'(c);
            for (int k = 0; k < PERIOD - 1; k++) begin
                if (3'(k) < nm) t = trellis(t, z).nxt;
            end
            if ((t ^ s0n) == 3'(c)) res = 3'(c);
        end
        return res;
    endfunction

endpackage

// File: rtl/dbcrsc_step.sv
module dbcrsc_step
    import dbcrsc_pkg::*;
(
    input  logic [2:0] st,
    input  couple_t    cpl,
    output step_t      res
);
    always_comb res = trellis(st, cpl);
endmodule

// File: rtl/dbcrsc_circ_map.sv
module dbcrsc_circ_map
    import dbcrsc_pkg::*;
(
    input  logic [2:0] n_mod,
    input  logic [2:0] s_final,
    output logic [2:0] s_circ
);
    always_comb s_circ = circ_of(n_mod, s_final);
endmodule

// File: rtl/dbcrsc_couple_buf.sv
module dbcrsc_couple_buf
    import dbcrsc_pkg::*;
#(
    parameter int DEPTH = MAX_N,
    parameter int BAW   = AW
) (
    input  logic           clk,
    input  logic           we,
    input  logic [BAW-1:0] waddr,
    input  couple_t        wdata,
    input  logic [BAW-1:0] raddr,
    output couple_t        rdata
);
    couple_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dbcrsc_enc.sv
module dbcrsc_enc
    import dbcrsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             y2_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_a,
    input  logic             in_b,
    output logic             busy,
    output logic             len_err,
    output logic             out_valid,
    output logic             out_a,
    output logic             out_b,
    output logic             out_y1,
    output logic             out_y2,
    output logic             out_last,
    output logic             out_mismatch,
    output logic [2:0]       circ_state
);
    phase_t           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_m1;
    logic [2:0]       n_mod;
    logic             y2_on;
    logic [2:0]       trel;
    logic [2:0]       sc;
    logic [LEN_W-1:0] len_rem;
    logic             len_ok;
    logic             at_end;
    couple_t          in_cpl;
    couple_t          buf_rd;
    couple_t          step_in;
    step_t            step_out;
    logic [2:0]       sc_next;

    assign in_cpl  = '{a: in_a, b: in_b};
    assign len_rem = blk_len % LEN_W'(PERIOD);
    assign len_ok  = (blk_len != '0) && (blk_len <= LEN_W'(MAX_N)) && (len_rem != '0);
    assign at_end  = (cnt == len_m1);
    assign step_in = (phase == PH_EMIT) ? buf_rd : in_cpl;
    assign busy    = (phase != PH_IDLE);
    assign in_ready = (phase == PH_LOAD);
    assign circ_state = sc;

    dbcrsc_step u_step (
        .st  (trel),
        .cpl (step_in),
        .res (step_out)
    );

    dbcrsc_circ_map u_map (
        .n_mod   (n_mod),
        .s_final (trel),
        .s_circ  (sc_next)
    );

    dbcrsc_couple_buf #(.DEPTH(MAX_N), .BAW(AW)) u_buf (
        .clk   (clk),
        .we    (in_ready && in_valid),
        .waddr (cnt[AW-1:0]),
        .wdata (in_cpl),
        .raddr (cnt[AW-1:0]),
        .rdata (buf_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            cnt          <= '0;
            len_m1       <= '0;
            n_mod        <= '0;
            y2_on        <= 1'b0;
            trel         <= '0;
            sc           <= '0;
            len_err      <= 1'b0;
            out_valid    <= 1'b0;
            out_a        <= 1'b0;
            out_b        <= 1'b0;
            out_y1       <= 1'b0;
            out_y2       <= 1'b0;
            out_last     <= 1'b0;
            out_mismatch <= 1'b0;
        end else begin
            len_err      <= 1'b0;
            out_valid    <= 1'b0;
            out_last     <= 1'b0;
            out_mismatch <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (len_ok) begin
                            phase  <= PH_LOAD;
                            cnt    <= '0;
                            len_m1 <= blk_len - 1'b1;
                            n_mod  <= len_rem[2:0];
                            y2_on  <= y2_en;
                            trel   <= '0;
                        end else begin
                            len_err <= 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (in_valid) begin
                        trel <= step_out.nxt;
                        if (at_end) begin
                            phase <= PH_CIRC;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CIRC: begin
                    sc    <= sc_next;
                    trel  <= sc_next;
                    phase <= PH_EMIT;
                end
                PH_EMIT: begin
                    trel      <= step_out.nxt;
                    out_valid <= 1'b1;
                    out_a     <= step_in.a;
                    out_b     <= step_in.b;
                    out_y1    <= step_out.y1;
                    out_y2    <= step_out.y2 & y2_on;
                    if (at_end) begin
                        out_last     <= 1'b1;
                        out_mismatch <= (step_out.nxt != sc);
                        phase        <= PH_IDLE;
                        cnt          <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbcrsc_enc_chk.sv
module dbcrsc_enc_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic in_ready,
    input logic len_err,
    input logic out_valid,
    input logic out_last,
    input logic out_mismatch,
    input logic out_y2,
    input logic y2_on
);
    a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r7_err_stays_idle: assert property (@(posedge clk) disable iff (rst)
        len_err |-> !busy);

    a_r3_ready_in_block: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);

    a_r5_last_is_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r5_words_in_block: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy));

    a_r9_circle_closes: assert property (@(posedge clk) disable iff (rst)
        out_last |-> !out_mismatch);

    a_r6_y2_silent: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !y2_on) |-> !out_y2);
endmodule

bind dbcrsc_enc dbcrsc_enc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .in_ready     (in_ready),
    .len_err      (len_err),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .out_mismatch (out_mismatch),
    .out_y2       (out_y2),
    .y2_on        (y2_on)
);

// File: tb/dbcrsc_enc_test.sv
module dbcrsc_enc_test;
    localparam int MAXN = 864;
    localparam int LW   = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LW-1:0] blk_len = '0;
    logic          y2_en = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_a = 1'b0;
    logic          in_b = 1'b0;
    logic          in_ready, busy, len_err, out_valid, out_a, out_b;
    logic          out_y1, out_y2, out_last, out_mismatch;
    logic [2:0]    circ_state;

    int checks = 0;
    int errors = 0;

    bit ra [1024];
    bit rb [1024];
    bit qa [1024];
    bit qb [1024];
    bit qy1 [1024];
    bit qy2 [1024];
    bit ql [1024];
    bit qm [1024];
    logic [2:0] qc [1024];
    int nout = 0;

    dbcrsc_enc uut (
        .clk(clk), .rst(rst), .start(start), .blk_len(blk_len), .y2_en(y2_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
        .busy(busy), .len_err(len_err), .out_valid(out_valid), .out_a(out_a),
        .out_b(out_b), .out_y1(out_y1), .out_y2(out_y2), .out_last(out_last),
        .out_mismatch(out_mismatch), .circ_state(circ_state)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (out_valid && nout < 1024) begin
            qa[nout] = out_a; qb[nout] = out_b; qy1[nout] = out_y1;
            qy2[nout] = out_y2; ql[nout] = out_last; qm[nout] = out_mismatch;
            qc[nout] = circ_state;
            nout++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference trellis from R2: s = {S1,S2,S3}
    function automatic logic [2:0] ref_next(logic [2:0] s, bit a, bit b);
        bit f;
        f = a ^ b ^ s[2] ^ s[0];
        return {f, s[2] ^ b, s[1] ^ b};
    endfunction

    function automatic logic [2:0] ref_run(logic [2:0] s0, int n);
        logic [2:0] s;
        s = s0;
        for (int i = 0; i < n; i++) s = ref_next(s, ra[i], rb[i]);
        return s;
    endfunction

    task automatic gen_data(input int n, input int seed);
        logic [15:0] lf;
        lf = 16'(seed) | 16'h1;
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ra[i] = lf[0];
            rb[i] = lf[3];
        end
    endtask

    task automatic pulse_start(input int n, input bit y2);
        @(negedge clk);
        start = 1'b1; blk_len = LW'(n); y2_en = y2;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n, input bit gaps, input bit hold_valid, input bit poke_start);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_a = ra[i]; in_b = rb[i];
            if (poke_start && i == n / 2) begin
                start = 1'b1; blk_len = LW'(3); y2_en = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = hold_valid;
        in_a = 1'b1; in_b = 1'b1;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic verify(input string tag, input int n, input bit y2);
        logic [2:0] s, cs;
        int found, bad;
        bit f;
        found = 0; cs = '0;
        for (int c = 0; c < 8; c++) begin
            if (ref_run(3'(c), n) == 3'(c)) begin found++; cs = 3'(c); end
        end
        check("R4", {tag, " unique circulation state"}, found, 1);
        check("R5", {tag, " word count"}, nout, n);
        check("R4", {tag, " circ_state"}, int'(qc[0]), int'(cs));
        bad = 0;
        s = cs;
        for (int i = 0; i < n && i < nout; i++) begin
            f = ra[i] ^ rb[i] ^ s[2] ^ s[0];
            if (qa[i] != ra[i] || qb[i] != rb[i]) begin
                bad++; $display("FAIL R5 %s systematic word %0d: actual %0d%0d expected %0d%0d",
                                tag, i, qa[i], qb[i], ra[i], rb[i]);
            end
            if (qy1[i] != (f ^ s[1] ^ s[0])) begin
                bad++; $display("FAIL R2 %s y1 word %0d: actual %0d expected %0d",
                                tag, i, qy1[i], f ^ s[1] ^ s[0]);
            end
            if (qy2[i] != (y2 & (f ^ s[0]))) begin
                bad++; $display("FAIL R6 %s y2 word %0d: actual %0d expected %0d",
                                tag, i, qy2[i], y2 & (f ^ s[0]));
            end
            if (ql[i] != (i == n - 1)) begin
                bad++; $display("FAIL R5 %s last word %0d: actual %0d expected %0d",
                                tag, i, ql[i], (i == n - 1));
            end
            if (qm[i]) begin
                bad++; $display("FAIL R9 %s mismatch word %0d: actual 1 expected 0", tag, i);
            end
            s = ref_next(s, ra[i], rb[i]);
        end
        checks++;
        if (bad != 0) errors++;
        check("R2", {tag, " closes on start state"}, int'(s), int'(cs));
    endtask

    task automatic run_block(input string tag, input int n, input bit y2, input bit gaps,
                             input bit hold, input bit poke, input int seed);
        gen_data(n, seed);
        nout = 0;
        pulse_start(n, y2);
        check("R3", {tag, " ready after start"}, int'(in_ready), 1);
        check("R3", {tag, " no word in pass 1"}, nout, 0);
        feed(n, gaps, hold, poke);
        check("R3", {tag, " ready dropped after N"}, int'(in_ready), 0);
        wait_idle();
        verify(tag, n, y2);
    endtask

    task automatic t_reset();
        check("R1", "busy", int'(busy), 0);
        check("R1", "in_ready", int'(in_ready), 0);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_last", int'(out_last), 0);
        check("R1", "out_mismatch", int'(out_mismatch), 0);
        check("R1", "len_err", int'(len_err), 0);
    endtask

    task automatic t_reject(input int n);
        pulse_start(n, 1'b1);
        check("R7", $sformatf("len_err for N=%0d", n), int'(len_err), 1);
        check("R7", $sformatf("busy for N=%0d", n), int'(busy), 0);
        @(negedge clk);
        check("R7", $sformatf("len_err one cycle N=%0d", n), int'(len_err), 0);
    endtask

    task automatic t_idle_valid();
        nout = 0;
        in_valid = 1'b1; in_a = 1'b1; in_b = 1'b0;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("R10", "no words from idle in_valid", nout, 0);
        check("R10", "still idle", int'(busy), 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_valid();
        run_block("n5_y2", 5, 1'b1, 1'b0, 1'b0, 1'b0, 11);
        run_block("n13_noy2_gaps", 13, 1'b0, 1'b1, 1'b1, 1'b0, 37);
        run_block("n1", 1, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        run_block("n9_hold", 9, 1'b1, 1'b0, 1'b1, 1'b0, 91);
        run_block("n6", 6, 1'b1, 1'b1, 1'b0, 1'b0, 203);
        run_block("n4_noy2", 4, 1'b0, 1'b0, 1'b0, 1'b0, 77);
        run_block("n40_poke_R8", 40, 1'b1, 1'b0, 1'b0, 1'b1, 313);
        run_block("n864_max", MAXN - 1 + 1, 1'b1, 1'b0, 1'b0, 1'b0, 999);
        t_reject(7);
        t_reject(0);
        t_reject(MAXN + 1);
        t_reject(14);
        run_block("n53_after_reject", 53, 1'b1, 1'b0, 1'b1, 1'b0, 4242);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule